// File: doc/BRIEF.md
# Digital TV Display Timing Generator

This block produces horizontal sync, vertical sync and data-enable for a digital TV output, together with the output pixel colour. A single pixel counter runs across the whole frame. Every vertical event (sync length, display window, active area) is a position measured in pixel clocks from the frame start, not in lines. A second counter gives the pixel position inside the current line. Software computes the pixel positions. The vertical window start is (vsync lines + back porch lines) × line length + skew, and the vertical window end is frame length − front porch lines × line length + skew − 1. In this way a horizontal skew moves the vertical display window.

Software programs the timing through a simple write port. All timing and colour fields go to a shadow copy only when the frame counter wraps, or at any time while the generator is disabled. A frame therefore never mixes old and new settings. Inside the display window the generator asks for a pixel with a combinational request. If the source cannot supply one, that is an underflow, and a programmable colour replaces the source pixels. With recovery enabled the replacement lasts to the end of the line. With recovery disabled it lasts to the end of the frame. An optional active-area rectangle restricts the source pixels to part of the window, and the border colour fills the rest of the window.

Top module: `dtv_timing_gen`

## Requirements
- R1: While rst_ni is low, and after it, until the generator is enabled, hsync_o, vsync_o, de_o, pix_req_o are 0 and pix_o is zero.
- R2: Register 1 holds the line length in pixels in [31:16] and the hsync width in [15:0]. The line position counts 0 up to line length − 1 and then wraps. Raw hsync is high while the line position is below the width.
- R3: Register 3 holds the frame length in pixels. The frame counter counts 0 up to frame length − 1 and then wraps to 0, and the line position returns to 0 at the same time. Raw vsync is high while the frame counter is below register 4.
- R4: Raw data-enable is high when the line position lies within register 2 ([15:0] first, [31:16] last, both inclusive) and the frame counter lies within registers 5 (first) and 6 (last), both inclusive.
- R5: In register 7, bit 0 inverts hsync_o, bit 1 inverts vsync_o and bit 2 inverts de_o. While disabled, each of these outputs sits at its polarity bit.
- R6: When bit 31 of register 12 is set, the active area is line position within register 11 ([15:0] first, [31:16] last) and frame counter within register 12 [30:0] and register 13, all inclusive. Window pixels outside it output the border: red from register 8 [11:0], green from register 8 [27:16], blue from register 9 [11:0].
- R7: pix_req_o is high while enabled inside the window and the active area. When pix_valid_i is then high, pix_i (red [35:24], green [23:12], blue [11:0]) appears on pix_o one clock later. Sync and enable outputs also lag the counters by one clock.
- R8: An underflow (pix_req_o high, pix_valid_i low) outputs the underflow colour from register 10 in that pixel. Each 8-bit field (red [23:16], green [15:8], blue [7:0]) is widened to 12 bits by appending its top 4 bits. With register 10 bit 31 set, the colour replaces active pixels to the end of the line.
- R9: With register 10 bit 31 clear, the underflow colour replaces active pixels until the frame counter wraps.
- R10: Writes to registers 1 to 13 while enabled take effect only from the next frame start.
- R11: Register 0 bit 0 enables the generator at once. Clearing it resets both counters and the underflow state, and drives pix_o to zero on the next clock.
- R12: Outside the display window pix_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Source pixel available |
| pix_i | input | 36 | Source pixel, 12 bits per component |
| pix_req_o | output | 1 | Pixel consumed this cycle |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_o | output | 36 | Output pixel colour |

## Verification
A frame counter with the wrong wrap point shifts vsync_o and de_o within the first frame. A slip of one cycle appears at the next vertical window edge, because that edge is a pixel count. A shadow copy loaded at the wrong time shows up as a sync edge at a changed position before the frame boundary. A stuck underflow flag shows up one line (recovery) or one frame (no recovery) after it should have cleared, when the source pixels fail to return on pix_o. The bench follows every output in every cycle against an independent model of these rules, so any such divergence is reported in the cycle it appears.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned DW   = 32;  // register data width
  localparam int unsigned AW   = 4;   // register index width
  localparam int unsigned HW   = 16;  // line position width
  localparam int unsigned FW   = 32;  // frame counter width
  localparam int unsigned CW   = 12;  // bits per colour component
  localparam int unsigned PW   = 3 * CW;
  localparam int unsigned UW   = 8;   // underflow colour bits per component
  localparam int unsigned NREG = 14;

  localparam logic [AW-1:0] A_CTRL   = 4'd0;
  localparam logic [AW-1:0] A_HTIME  = 4'd1;
  localparam logic [AW-1:0] A_HWIN   = 4'd2;
  localparam logic [AW-1:0] A_FLEN   = 4'd3;
  localparam logic [AW-1:0] A_VSLEN  = 4'd4;
  localparam logic [AW-1:0] A_VWS    = 4'd5;
  localparam logic [AW-1:0] A_VWE    = 4'd6;
  localparam logic [AW-1:0] A_POL    = 4'd7;
  localparam logic [AW-1:0] A_BRD_RG = 4'd8;
  localparam logic [AW-1:0] A_BRD_B  = 4'd9;
  localparam logic [AW-1:0] A_UFLOW  = 4'd10;
  localparam logic [AW-1:0] A_ACTH   = 4'd11;
  localparam logic [AW-1:0] A_ACTVS  = 4'd12;
  localparam logic [AW-1:0] A_ACTVE  = 4'd13;

  typedef struct packed {
    logic [HW-1:0] hper;
    logic [HW-1:0] hsw;
    logic [HW-1:0] hws;
    logic [HW-1:0] hwe;
    logic [FW-1:0] flen;
    logic [FW-1:0] vslen;
    logic [FW-1:0] vws;
    logic [FW-1:0] vwe;
    logic [2:0]    pol;
    logic [PW-1:0] border;
    logic          uf_rec;
    logic [PW-1:0] uf_col;
    logic          act_en;
    logic [HW-1:0] ahs;
    logic [HW-1:0] ahe;
    logic [FW-1:0] avs;
    logic [FW-1:0] ave;
  } cfg_t;

  function automatic logic [CW-1:0] widen(input logic [UW-1:0] c);
    return {c, c[UW-1 -: CW-UW]};
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  output logic          en_o,
  output cfg_t          sh_o
);
  cfg_t live_q, sh_q;
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL:   en_q <= wdata_i[0];
        A_HTIME:  begin
          live_q.hper <= wdata_i[DW-1:HW];
          live_q.hsw  <= wdata_i[HW-1:0];
        end
        A_HWIN:   begin
          live_q.hwe <= wdata_i[DW-1:HW];
          live_q.hws <= wdata_i[HW-1:0];
        end
        A_FLEN:   live_q.flen  <= wdata_i;
        A_VSLEN:  live_q.vslen <= wdata_i;
        A_VWS:    live_q.vws   <= wdata_i;
        A_VWE:    live_q.vwe   <= wdata_i;
        A_POL:    live_q.pol   <= wdata_i[2:0];
        A_BRD_RG: begin
          live_q.border[PW-1 -: CW]   <= wdata_i[CW-1:0];
          live_q.border[2*CW-1 -: CW] <= wdata_i[HW+CW-1:HW];
        end
        A_BRD_B:  live_q.border[CW-1:0] <= wdata_i[CW-1:0];
        A_UFLOW:  begin
          live_q.uf_rec <= wdata_i[DW-1];
          live_q.uf_col <= {widen(wdata_i[3*UW-1 -: UW]),
                            widen(wdata_i[2*UW-1 -: UW]),
                            widen(wdata_i[UW-1:0])};
        end
        A_ACTH:   begin
          live_q.ahe <= wdata_i[DW-1:HW];
          live_q.ahs <= wdata_i[HW-1:0];
        end
        A_ACTVS:  begin
          live_q.act_en <= wdata_i[DW-1];
          live_q.avs    <= {1'b0, wdata_i[DW-2:0]};
        end
        A_ACTVE:  live_q.ave <= wdata_i;
        default: ;
      endcase
    end
  end

  // shadow follows live while idle, else only at frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= live_q;
  end

  assign en_o = en_q;
  assign sh_o = sh_q;
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [HW-1:0] hper_i,
  input  logic [FW-1:0] flen_i,
  output logic [FW-1:0] fcnt_o,
  output logic [HW-1:0] hpos_o,
  output logic          frame_wrap_o,
  output logic          line_end_o,
  output logic          load_o
);
  logic [FW-1:0] fcnt_q;
  logic [HW-1:0] hpos_q;

  assign frame_wrap_o = en_i && (fcnt_q >= flen_i - FW'(1));
  assign line_end_o   = en_i && (frame_wrap_o || (hpos_q >= hper_i - HW'(1)));
  assign load_o       = !en_i || frame_wrap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      hpos_q <= '0;
    end else if (load_o) begin
      fcnt_q <= '0;
      hpos_q <= '0;
    end else begin
      fcnt_q <= fcnt_q + FW'(1);
      hpos_q <= line_end_o ? '0 : hpos_q + HW'(1);
    end
  end

  assign fcnt_o = fcnt_q;
  assign hpos_o = hpos_q;
endmodule

// File: rtl/dtg_pixel.sv
module dtg_pixel
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  cfg_t          sh_i,
  input  logic [FW-1:0] fcnt_i,
  input  logic [HW-1:0] hpos_i,
  input  logic          frame_wrap_i,
  input  logic          line_end_i,
  input  logic          pix_valid_i,
  input  logic [PW-1:0] pix_i,
  output logic          req_o,
  output logic          win_o,
  output logic          uf_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [PW-1:0] pix_o
);
  logic hs_raw, vs_raw, win, act_area, uf_evt, uf_q;
  logic [PW-1:0] pix_d;

  assign hs_raw   = hpos_i < sh_i.hsw;
  assign vs_raw   = fcnt_i < sh_i.vslen;
  assign win      = (hpos_i >= sh_i.hws) && (hpos_i <= sh_i.hwe) &&
                    (fcnt_i >= sh_i.vws) && (fcnt_i <= sh_i.vwe);
  assign act_area = !sh_i.act_en ||
                    ((hpos_i >= sh_i.ahs) && (hpos_i <= sh_i.ahe) &&
                     (fcnt_i >= sh_i.avs) && (fcnt_i <= sh_i.ave));
  assign req_o    = en_i && win && act_area;
  assign uf_evt   = req_o && !pix_valid_i;

  always_comb begin
    if (!win)                 pix_d = '0;
    else if (!act_area)       pix_d = sh_i.border;
    else if (uf_q || uf_evt)  pix_d = sh_i.uf_col;
    else                      pix_d = pix_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_o   <= '0;
      uf_q    <= 1'b0;
    end else if (!en_i) begin
      hsync_o <= sh_i.pol[0];
      vsync_o <= sh_i.pol[1];
      de_o    <= sh_i.pol[2];
      pix_o   <= '0;
      uf_q    <= 1'b0;
    end else begin
      hsync_o <= hs_raw ^ sh_i.pol[0];
      vsync_o <= vs_raw ^ sh_i.pol[1];
      de_o    <= win ^ sh_i.pol[2];
      pix_o   <= pix_d;
      if (frame_wrap_i || (line_end_i && sh_i.uf_rec)) uf_q <= 1'b0;
      else if (uf_evt)                                  uf_q <= 1'b1;
    end
  end

  assign win_o = win;
  assign uf_o  = uf_q;
endmodule

// File: rtl/dtv_timing_gen.sv
module dtv_timing_gen
  import dtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          pix_valid_i,
  input  logic [PW-1:0] pix_i,
  output logic          pix_req_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [PW-1:0] pix_o
);
  logic          en_w, load_w, frame_wrap_w, line_end_w, win_w, uf_w;
  logic [FW-1:0] fcnt_w;
  logic [HW-1:0] hpos_w;
  cfg_t          sh_w;

  dtg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .load_i  (load_w),
    .en_o    (en_w),
    .sh_o    (sh_w)
  );

  dtg_counters u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_w),
    .hper_i       (sh_w.hper),
    .flen_i       (sh_w.flen),
    .fcnt_o       (fcnt_w),
    .hpos_o       (hpos_w),
    .frame_wrap_o (frame_wrap_w),
    .line_end_o   (line_end_w),
    .load_o       (load_w)
  );

  dtg_pixel u_pix (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_w),
    .sh_i         (sh_w),
    .fcnt_i       (fcnt_w),
    .hpos_i       (hpos_w),
    .frame_wrap_i (frame_wrap_w),
    .line_end_i   (line_end_w),
    .pix_valid_i  (pix_valid_i),
    .pix_i        (pix_i),
    .req_o        (pix_req_o),
    .win_o        (win_w),
    .uf_o         (uf_w),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .de_o         (de_o),
    .pix_o        (pix_o)
  );
endmodule

// File: rtl/dtv_timing_gen_chk.sv
module dtv_timing_gen_chk
  import dtg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          wrap_i,
  input logic          line_end_i,
  input logic [FW-1:0] fcnt_i,
  input logic [HW-1:0] hpos_i,
  input logic          win_i,
  input logic          uf_i,
  input logic          uf_rec_i,
  input logic [HW-1:0] hper_sh_i,
  input logic [PW-1:0] out_pix_i
);
  // R3
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (fcnt_i == '0) && (hpos_i == '0));

  // R2
  line_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_i |=> (hpos_i == '0));

  // R11
  idle_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fcnt_i == '0) && (hpos_i == '0) && (out_pix_i == '0) && !uf_i);

  // R12
  blank_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !win_i) |=> (out_pix_i == '0));

  // R10
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i) |=> $stable(hper_sh_i));

  // R8
  uf_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && uf_rec_i && line_end_i) |=> !uf_i);

  // R9
  uf_frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !uf_i);
endmodule

bind dtv_timing_gen dtv_timing_gen_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_w),
  .wrap_i     (frame_wrap_w),
  .line_end_i (line_end_w),
  .fcnt_i     (fcnt_w),
  .hpos_i     (hpos_w),
  .win_i      (win_w),
  .uf_i       (uf_w),
  .uf_rec_i   (sh_w.uf_rec),
  .hper_sh_i  (sh_w.hper),
  .out_pix_i  (pix_o)
);

// File: tb/dtv_timing_gen_tb.sv
`timescale 1ns/1ps
module dtv_timing_gen_tb_top;
  import dtg_pkg::*;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_addr_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic          pix_valid_i = 1'b1;
  logic [PW-1:0] pix_i = '0;
  logic          pix_req_o, hsync_o, vsync_o, de_o;
  logic [PW-1:0] pix_o;

  int unsigned n_vec = 0, n_fail = 0;
  int unsigned uf_mod = 0;
  string       phase = "R1";

  always #2.5 clk_i = ~clk_i;

  dtv_timing_gen dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .pix_valid_i, .pix_i, .pix_req_o, .hsync_o, .vsync_o, .de_o, .pix_o
  );

  // ---------------- reference model built from the requirements ----------------
  logic [DW-1:0] m_reg [NREG];
  logic [DW-1:0] m_sh  [NREG];
  logic [FW-1:0] m_f;
  logic [HW-1:0] m_h;
  logic          m_uf;
  logic          e_hs, e_vs, e_de;
  logic [PW-1:0] e_pix;
  logic [1:0]    e_kind;   // 0 blank, 1 border, 2 underflow colour, 3 source
  logic [2:0]    e_pol;
  logic          e_rec;

  logic          m_en, m_wrap, m_lend, m_win, m_act, m_req, m_evt, b_rec;
  logic [HW-1:0] b_hper, b_hsw;
  logic [2:0]    b_pol;
  logic [PW-1:0] b_border, b_ucol;

  function automatic logic [CW-1:0] w8(input logic [7:0] c);
    return {c, c[7:4]};
  endfunction

  always_comb begin
    m_en     = m_reg[A_CTRL][0];
    b_hper   = m_sh[A_HTIME][31:16];
    b_hsw    = m_sh[A_HTIME][15:0];
    b_pol    = m_sh[A_POL][2:0];
    b_border = {m_sh[A_BRD_RG][11:0], m_sh[A_BRD_RG][27:16], m_sh[A_BRD_B][11:0]};
    b_rec    = m_sh[A_UFLOW][31];
    b_ucol   = {w8(m_sh[A_UFLOW][23:16]), w8(m_sh[A_UFLOW][15:8]), w8(m_sh[A_UFLOW][7:0])};
    m_wrap   = m_en && (m_f >= m_sh[A_FLEN] - 32'd1);
    m_lend   = m_en && (m_wrap || (m_h >= b_hper - 16'd1));
    m_win    = (m_h >= m_sh[A_HWIN][15:0]) && (m_h <= m_sh[A_HWIN][31:16]) &&
               (m_f >= m_sh[A_VWS]) && (m_f <= m_sh[A_VWE]);
    m_act    = !m_sh[A_ACTVS][31] ||
               ((m_h >= m_sh[A_ACTH][15:0]) && (m_h <= m_sh[A_ACTH][31:16]) &&
                (m_f >= {1'b0, m_sh[A_ACTVS][30:0]}) && (m_f <= m_sh[A_ACTVE]));
    m_req    = m_en && m_win && m_act;
    m_evt    = m_req && !pix_valid_i;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) begin
        m_reg[i] <= '0;
        m_sh[i]  <= '0;
      end
      m_f <= '0; m_h <= '0; m_uf <= 1'b0;
      e_hs <= 1'b0; e_vs <= 1'b0; e_de <= 1'b0; e_pix <= '0;
      e_kind <= 2'd0; e_pol <= 3'd0; e_rec <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (cfg_we_i && cfg_addr_i == AW'(i)) m_reg[i] <= cfg_wdata_i;
        if (!m_en || m_wrap) m_sh[i] <= m_reg[i];
      end
      e_pol <= b_pol;
      e_rec <= b_rec;
      if (!m_en) begin
        e_hs <= b_pol[0]; e_vs <= b_pol[1]; e_de <= b_pol[2];
        e_pix <= '0; e_kind <= 2'd0;
        m_f <= '0; m_h <= '0; m_uf <= 1'b0;
      end else begin
        e_hs <= (m_h < b_hsw) ^ b_pol[0];
        e_vs <= (m_f < m_sh[A_VSLEN]) ^ b_pol[1];
        e_de <= m_win ^ b_pol[2];
        if (!m_win)             begin e_pix <= '0;       e_kind <= 2'd0; end
        else if (!m_act)        begin e_pix <= b_border; e_kind <= 2'd1; end
        else if (m_uf || m_evt) begin e_pix <= b_ucol;   e_kind <= 2'd2; end
        else                    begin e_pix <= pix_i;    e_kind <= 2'd3; end
        if (m_wrap) begin m_f <= '0; m_h <= '0; end
        else begin m_f <= m_f + 32'd1; m_h <= m_lend ? 16'd0 : m_h + 16'd1; end
        if (m_wrap || (m_lend && b_rec)) m_uf <= 1'b0;
        else if (m_evt)                  m_uf <= 1'b1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string sig, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h (phase %s, t=%0t)", req, sig, act, exp, phase, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      // R1
      chk("R1", "reset outputs", {pix_o, hsync_o, vsync_o, de_o, pix_req_o} , '0);
    end else begin
      chk(e_pol[0] ? "R5" : "R2", "hsync_o", PW'(hsync_o), PW'(e_hs));
      chk(e_pol[1] ? "R5" : "R3", "vsync_o", PW'(vsync_o), PW'(e_vs));
      chk(e_pol[2] ? "R5" : "R4", "de_o",    PW'(de_o),    PW'(e_de));
      chk("R7", "pix_req_o", PW'(pix_req_o), PW'(m_req));
      case (e_kind)
        2'd0:    chk("R12", "pix_o blank", pix_o, e_pix);
        2'd1:    chk("R6",  "pix_o border", pix_o, e_pix);
        2'd2:    chk(e_rec ? "R8" : "R9", "pix_o underflow", pix_o, e_pix);
        default: chk("R7",  "pix_o source", pix_o, e_pix);
      endcase
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk_i) begin
    pix_i       <= PW'({$urandom, $urandom});
    pix_valid_i <= (uf_mod == 0) || (($urandom % uf_mod) != 0);
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    cfg_we_i <= 1'b1; cfg_addr_i <= a; cfg_wdata_i <= d;
    @(negedge clk_i);
    cfg_we_i <= 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // programs geometry from porch/size values with the stated formulas
  task automatic prog(input int hsw, input int hbp, input int w, input int hfp,
                      input int vsw, input int vbp, input int h, input int vfp,
                      input int skew, output int hper, output int flen);
    int vws, vwe;
    hper = hsw + hbp + w + hfp;
    flen = (vsw + vbp + h + vfp) * hper;
    vws  = (vsw + vbp) * hper + skew;
    vwe  = flen - vfp * hper + skew - 1;
    wr(A_HTIME, {16'(hper), 16'(hsw)});
    wr(A_HWIN,  {16'(hper - hfp - 1), 16'(hsw + hbp)});
    wr(A_FLEN,  32'(flen));
    wr(A_VSLEN, 32'(vsw * hper));
    wr(A_VWS,   32'(vws));
    wr(A_VWE,   32'(vwe));
  endtask

  initial begin
    int hper, flen;
    void'($urandom(32'h1F2E3D4C));
    run(4);
    rst_ni <= 1'b1;
    run(3);

    phase = "R2 R3 R4 R12";
    prog(2, 3, 10, 2, 2, 2, 5, 2, 1, hper, flen);
    wr(A_BRD_RG, {4'h0, 12'h5A5, 4'h0, 12'hC3C});
    wr(A_BRD_B,  32'h0000_0777);
    wr(A_UFLOW,  32'h0012_34AB);
    wr(A_CTRL,   32'd1);
    run(3 * flen);

    phase = "R5 R10";
    wr(A_POL, 32'd7);
    run(2 * flen);

    phase = "R10";
    run(flen / 3);
    wr(A_HTIME, {16'(hper), 16'd5});
    run(2 * flen);

    phase = "R6";
    wr(A_ACTH,  {16'd11, 16'd7});
    wr(A_ACTVS, {1'b1, 31'd86});
    wr(A_ACTVE, 32'd136);
    run(2 * flen);

    phase = "R8";
    uf_mod = 9;
    wr(A_UFLOW, 32'h80A5_5A3C);
    run(3 * flen);

    phase = "R9";
    wr(A_UFLOW, 32'h003C_C30F);
    run(3 * flen);

    phase = "R11";
    run(flen / 2);
    wr(A_CTRL, 32'd0);
    run(20);
    wr(A_CTRL, 32'd1);
    run(flen);

    phase = "R7";
    for (int it = 0; it < 5; it++) begin
      wr(A_CTRL, 32'd0);
      run(2);
      prog(1 + $urandom % 4, 1 + $urandom % 4, 4 + $urandom % 13, 1 + $urandom % 4,
           1 + $urandom % 2, 1 + $urandom % 3, 2 + $urandom % 5, 1 + $urandom % 3,
           $urandom % 4, hper, flen);
      wr(A_POL,   32'($urandom % 8));
      wr(A_UFLOW, $urandom);
      wr(A_ACTVS, 32'd0);
      uf_mod = (it % 2 == 0) ? 0 : 7;
      wr(A_CTRL, 32'd1);
      run(3 * flen + 10);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: run did not complete (phase %s)", phase);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule